// File: doc/BRIEF.md
# I2C Slave Register Bank for a Step-Down Regulator

This block is the serial control interface of a programmable buck regulator. It is an I2C-compatible slave that runs entirely on a fast system clock. It oversamples the SCL and SDA pins through two-flop synchronisers and detects START, STOP and clock edges in that clock domain. It drives SDA only as an open-drain pull-down enable.

A host selects the slave with a 7-bit address. The address is 0x40 by default, or 0x41 when the `ADDR_ALT` parameter is set. The host then sends a register pointer, followed by data bytes to write. To read, it issues a repeated START with the read bit set and clocks the data out. The bank holds six registers:
- two output-select registers, each with an enable bit, a forced-PWM bit and a 6-bit voltage code;
- a control register with a discharge enable, a slew-rate code and a self-clearing soft-reset bit;
- two fixed identification registers;
- a status register that mirrors a power-good input.

The register contents are presented on output ports for the regulator's analog and ramp logic.

Top module: `i2c_reg_bank`

## Requirements
- R1: A STOP (SDA rising while SCL high) returns the slave to idle and discards a partial byte. A START (SDA falling while SCL high) in the middle of a byte abandons that byte and begins a new address phase.
- R2: The address byte carries the 7-bit address in bits 7:1 and R/W in bit 0 (0 write, 1 read). The slave acknowledges only its own address (0x40 with the default parameter). On a mismatch it never pulls SDA low and ignores the rest of the transaction.
- R3: Every byte the slave receives after a matching address is acknowledged by SDA low during the ninth SCL pulse. This holds for pointer bytes, data bytes and writes to read-only or unmapped locations.
- R4: In a write, the first byte after the address loads the register pointer. Each later data byte is written to the pointed register, and the pointer then advances by one.
- R5: Registers 0x00 and 0x01 are fully writable, with enable in bit 7, forced-PWM in bit 6 and the voltage code in bits 5:0. Both reset to 0x97, and their contents appear on `vsel0Q` and `vsel1Q`.
- R6: Register 0x02 keeps discharge enable in bit 7 and the slew code in bits 6:4. It resets to 0x80, and bits 3:0 always read 0, so writing 0xFB reads back 0xF0.
- R7: Writing register 0x02 with bit 2 set restores registers 0x00 to 0x02 to their reset values in one step. Bit 2 never reads back as 1.
- R8: Register 0x03 always reads 0x88 and register 0x04 always reads 0x01. Writes to them are acknowledged and change nothing.
- R9: Register 0x05 reads `pgoodIn` in bit 7, with bits 6:0 zero.
- R10: Reads shift data out MSB first from the pointed register, and the pointer advances after each byte. After the master NACKs a byte, the slave releases SDA.
- R11: Addresses 0x06 and above read 0x00, and writes to them change no register.
- R12: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock pin level |
| sdaIn | input | 1 | Serial data pin level |
| pgoodIn | input | 1 | Power-good status from the ramp logic |
| sdaDrvLow | output | 1 | 1 pulls SDA low (open-drain enable) |
| vsel0Q | output | 8 | Output-select register 0 contents |
| vsel1Q | output | 8 | Output-select register 1 contents |
| ctrlQ | output | 8 | Control register contents |

## Verification
Single-register and multi-byte write and read bursts are driven at random pointers. This separates correct pointer advance from a fixed pointer, and separates the writable, read-only and unmapped decodes. Directed cases cover the following:
- a control write with the soft-reset bit clear and then set, which tells masking apart from the restore;
- a wrong slave address, which must leave every register untouched;
- a STOP and a START inside a byte, which must not produce a write;
- the status register read with power-good at each level.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
  localparam int REG_W   = 8;
  localparam int NUM_SEL = 2;
  localparam logic [6:0] BASE_ADDR = 7'h40;

  localparam logic [REG_W-1:0] SEL_RST    = 8'h97;
  localparam logic [REG_W-1:0] CTRL_RST   = 8'h80;
  localparam logic [REG_W-1:0] CTRL_WMASK = 8'hF0;
  localparam logic [REG_W-1:0] ID_VENDOR  = 8'h88;
  localparam logic [REG_W-1:0] ID_REV     = 8'h01;

  localparam logic [REG_W-1:0] A_SEL0 = 8'h00;
  localparam logic [REG_W-1:0] A_SEL1 = 8'h01;
  localparam logic [REG_W-1:0] A_CTRL = 8'h02;
  localparam logic [REG_W-1:0] A_ID1  = 8'h03;
  localparam logic [REG_W-1:0] A_ID2  = 8'h04;
  localparam logic [REG_W-1:0] A_STAT = 8'h05;
  localparam int SOFT_RST_BIT = 2;

  typedef struct packed {
    logic             ptrLoad;
    logic             wrData;
    logic             rdNext;
    logic [REG_W-1:0] byteVal;
  } rb_stb_t;
endpackage

// File: rtl/i2c_rb_ctrl.sv
module i2c_rb_ctrl
  import i2c_rb_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h40,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic [REG_W-1:0] rdData,
  output rb_stb_t          stb,
  output logic             sdaDrvLow
);
  localparam int CNT_W = $clog2(REG_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(REG_W);

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_PTR, ST_WR, ST_RD} st_t;

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev, sclS, sdaS;
  logic startDet, stopDet, sclRise, sclFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS     = sclSync[SYNC_STAGES-1];
  assign sdaS     = sdaSync[SYNC_STAGES-1];
  assign startDet = sclS && sclPrev && sdaPrev && !sdaS;
  assign stopDet  = sclS && sclPrev && !sdaPrev && sdaS;
  assign sclRise  = sclS && !sclPrev;
  assign sclFall  = !sclS && sclPrev;

  st_t              state;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] bitIdx;
  logic             inAck, isRead, mAck;
  logic [REG_W-1:0] shReg, txReg;

  assign bitIdx = CNT_W'(REG_W - 1) - bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      inAck     <= 1'b0;
      isRead    <= 1'b0;
      mAck      <= 1'b0;
      shReg     <= '0;
      txReg     <= '0;
      sdaDrvLow <= 1'b0;
      stb       <= '0;
    end else begin
      stb.ptrLoad <= 1'b0;
      stb.wrData  <= 1'b0;
      stb.rdNext  <= 1'b0;
      if (stopDet) begin
        state     <= ST_IDLE;
        sdaDrvLow <= 1'b0;
        inAck     <= 1'b0;
        bitCnt    <= '0;
      end else if (startDet) begin
        state     <= ST_ADDR;
        sdaDrvLow <= 1'b0;
        inAck     <= 1'b0;
        bitCnt    <= '0;
      end else if (state == ST_RD) begin
        if (sclRise) begin
          if (inAck) mAck <= !sdaS;
          else       bitCnt <= bitCnt + 1'b1;
        end
        if (sclFall) begin
          if (inAck) begin
            inAck <= 1'b0;
            if (mAck) begin
              txReg      <= rdData;
              sdaDrvLow  <= !rdData[REG_W-1];
              stb.rdNext <= 1'b1;
              bitCnt     <= '0;
            end else begin
              state     <= ST_IDLE;
              sdaDrvLow <= 1'b0;
            end
          end else if (bitCnt == LAST_BIT) begin
            sdaDrvLow <= 1'b0;
            inAck     <= 1'b1;
          end else begin
            sdaDrvLow <= !txReg[bitIdx[$clog2(REG_W)-1:0]];
          end
        end
      end else if (state != ST_IDLE) begin
        if (sclRise && !inAck && bitCnt != LAST_BIT) begin
          shReg  <= {shReg[REG_W-2:0], sdaS};
          bitCnt <= bitCnt + 1'b1;
        end
        if (sclFall) begin
          if (inAck) begin
            inAck     <= 1'b0;
            sdaDrvLow <= 1'b0;
            bitCnt    <= '0;
            if (state == ST_ADDR) begin
              if (isRead) begin
                state      <= ST_RD;
                txReg      <= rdData;
                sdaDrvLow  <= !rdData[REG_W-1];
                stb.rdNext <= 1'b1;
              end else begin
                state <= ST_PTR;
              end
            end else if (state == ST_PTR) begin
              state <= ST_WR;
            end
          end else if (bitCnt == LAST_BIT) begin
            case (state)
              ST_ADDR: begin
                if (shReg[REG_W-1:1] == SLAVE_ADDR) begin
                  sdaDrvLow <= 1'b1;
                  isRead    <= shReg[0];
                  inAck     <= 1'b1;
                end else begin
                  state <= ST_IDLE;
                end
              end
              ST_PTR: begin
                sdaDrvLow   <= 1'b1;
                inAck       <= 1'b1;
                stb.ptrLoad <= 1'b1;
                stb.byteVal <= shReg;
              end
              ST_WR: begin
                sdaDrvLow   <= 1'b1;
                inAck       <= 1'b1;
                stb.wrData  <= 1'b1;
                stb.byteVal <= shReg;
              end
              default: ;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_rb_regs.sv
module i2c_rb_regs
  import i2c_rb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  rb_stb_t          stb,
  input  logic             pgoodIn,
  output logic [REG_W-1:0] rdData,
  output logic [REG_W-1:0] selQ [NUM_SEL],
  output logic [REG_W-1:0] ctrlQ
);
  logic [REG_W-1:0] ptrQ;
  logic             softRst;

  assign softRst = stb.wrData && (ptrQ == A_CTRL) && stb.byteVal[SOFT_RST_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (stb.ptrLoad) begin
      ptrQ <= stb.byteVal;
    end else if (stb.wrData || stb.rdNext) begin
      ptrQ <= ptrQ + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
    logic [REG_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                  q <= SEL_RST;
      else if (softRst)                           q <= SEL_RST;
      else if (stb.wrData && ptrQ == REG_W'(g))   q <= stb.byteVal;
    end
    assign selQ[g] = q;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             ctrlQ <= CTRL_RST;
    else if (softRst)                      ctrlQ <= CTRL_RST;
    else if (stb.wrData && ptrQ == A_CTRL) ctrlQ <= stb.byteVal & CTRL_WMASK;
  end

  always_comb begin
    case (ptrQ)
      A_SEL0:  rdData = selQ[0];
      A_SEL1:  rdData = selQ[1];
      A_CTRL:  rdData = ctrlQ;
      A_ID1:   rdData = ID_VENDOR;
      A_ID2:   rdData = ID_REV;
      A_STAT:  rdData = {pgoodIn, {(REG_W-1){1'b0}}};
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
  import i2c_rb_pkg::*;
#(
  parameter bit ADDR_ALT = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       pgoodIn,
  output logic       sdaDrvLow,
  output logic [7:0] vsel0Q,
  output logic [7:0] vsel1Q,
  output logic [7:0] ctrlQ
);
  localparam logic [6:0] SLAVE_ADDR = {BASE_ADDR[6:1], ADDR_ALT};

  rb_stb_t          stb;
  logic [REG_W-1:0] rdData;
  logic [REG_W-1:0] selQ [NUM_SEL];

  i2c_rb_ctrl #(.SLAVE_ADDR(SLAVE_ADDR), .SYNC_STAGES(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rdData(rdData), .stb(stb), .sdaDrvLow(sdaDrvLow)
  );

  i2c_rb_regs u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .pgoodIn(pgoodIn),
    .rdData(rdData), .selQ(selQ), .ctrlQ(ctrlQ)
  );

  assign vsel0Q = selQ[0];
  assign vsel1Q = selQ[1];
endmodule

// File: rtl/i2c_reg_bank_chk.sv
module i2c_reg_bank_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       sdaDrvLow,
  input logic       ptrLoad,
  input logic       wrData,
  input logic       rdNext,
  input logic [7:0] vsel0Q,
  input logic [7:0] vsel1Q,
  input logic [7:0] ctrlQ
);
  // R6 R7
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlQ[3:0] == 4'h0);

  // R4 R8 R11
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrData |=> $stable(vsel0Q) && $stable(vsel1Q) && $stable(ctrlQ));

  // R12
  sda_change_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDrvLow) |-> !sclIn);

  // R4 R10
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ptrLoad, wrData, rdNext}));
endmodule

bind i2c_reg_bank i2c_reg_bank_chk u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaDrvLow(sdaDrvLow),
  .ptrLoad(stb.ptrLoad), .wrData(stb.wrData), .rdNext(stb.rdNext),
  .vsel0Q(vsel0Q), .vsel1Q(vsel1Q), .ctrlQ(ctrlQ)
);

// File: tb/test_i2c_reg_bank.sv
`timescale 1ns/1ps
module test_i2c_reg_bank;
  localparam int Q = 8;
  localparam logic [6:0] MY_ADDR = 7'h40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1, pgood = 1'b0;
  logic sdaDrvLow;
  logic [7:0] vsel0Q, vsel1Q, ctrlQ;
  wire sdaLine = sdaM & ~sdaDrvLow;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] mReg [3];
  logic [7:0] wrBuf [4];

  always #2.5 clk = ~clk;

  i2c_reg_bank i_i2c_reg_bank (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .pgoodIn(pgood),
    .sdaDrvLow(sdaDrvLow), .vsel0Q(vsel0Q), .vsel1Q(vsel1Q), .ctrlQ(ctrlQ)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expRd(input int a);
    case (a)
      0: return mReg[0];
      1: return mReg[1];
      2: return mReg[2];
      3: return 8'h88;
      4: return 8'h01;
      5: return {pgood, 7'b0};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tagOf(input int a);
    if (a == 3 || a == 4) return "R8";
    if (a == 5) return "R9";
    if (a > 5) return "R11";
    return "R10";
  endfunction

  task automatic modelWrite(input int a, input logic [7:0] v);
    if (a == 2 && v[2]) begin
      mReg[0] = 8'h97; mReg[1] = 8'h97; mReg[2] = 8'h80;
    end else if (a < 2) mReg[a] = v;
    else if (a == 2) mReg[2] = v & 8'hF0;
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; qwait(); sclM = 1'b1; qwait(); sdaM = 1'b0; qwait(); sclM = 1'b0; qwait();
  endtask

  task automatic busStop();
    sdaM = 1'b0; qwait(); sclM = 1'b1; qwait(); sdaM = 1'b1; qwait();
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; qwait(); sclM = 1'b1; qwait(); qwait(); sclM = 1'b0; qwait();
  endtask

  task automatic recvBit(output logic b);
    sdaM = 1'b1; qwait(); sclM = 1'b1; qwait(); b = sdaLine; qwait(); sclM = 1'b0; qwait();
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    recvBit(ack);
  endtask

  task automatic recvByte(input logic nack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      recvBit(b);
      v[i] = b;
    end
    sendBit(nack);
  endtask

  task automatic checkPorts(input string req);
    chk(vsel0Q == mReg[0], req, vsel0Q, mReg[0]);
    chk(vsel1Q == mReg[1], req, vsel1Q, mReg[1]);
    chk(ctrlQ == mReg[2], req, ctrlQ, mReg[2]);
  endtask

  task automatic doWrite(input logic [7:0] ptr, input int n);
    logic ack;
    busStart();
    sendByte({MY_ADDR, 1'b0}, ack); chk(ack == 1'b0, "R2", {7'b0, ack}, 8'h00);
    sendByte(ptr, ack);             chk(ack == 1'b0, "R3", {7'b0, ack}, 8'h00);
    for (int i = 0; i < n; i++) begin
      sendByte(wrBuf[i], ack);      chk(ack == 1'b0, "R3", {7'b0, ack}, 8'h00);
      modelWrite(int'(ptr) + i, wrBuf[i]);
    end
    busStop();
    checkPorts("R4");
  endtask

  task automatic doRead(input logic [7:0] ptr, input int n);
    logic ack;
    logic [7:0] v;
    busStart();
    sendByte({MY_ADDR, 1'b0}, ack); chk(ack == 1'b0, "R2", {7'b0, ack}, 8'h00);
    sendByte(ptr, ack);             chk(ack == 1'b0, "R3", {7'b0, ack}, 8'h00);
    busStart();
    sendByte({MY_ADDR, 1'b1}, ack); chk(ack == 1'b0, "R2", {7'b0, ack}, 8'h00);
    for (int i = 0; i < n; i++) begin
      recvByte(i == n - 1, v);
      chk(v == expRd(int'(ptr) + i), tagOf(int'(ptr) + i), v, expRd(int'(ptr) + i));
    end
    chk(sdaDrvLow == 1'b0, "R10", {7'b0, sdaDrvLow}, 8'h00);
    busStop();
  endtask

  initial begin
    logic ack;
    void'($urandom(32'd4242));
    mReg[0] = 8'h97; mReg[1] = 8'h97; mReg[2] = 8'h80;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // reset state R5 R6
    checkPorts("R5");
    chk(sdaDrvLow == 1'b0, "R5", {7'b0, sdaDrvLow}, 8'h00);

    // full map read R5 R6 R8 R9
    doRead(8'h00, 6);
    pgood = 1'b1;
    doRead(8'h05, 1);

    // writable registers and control masking R5 R6
    wrBuf[0] = 8'h3C; wrBuf[1] = 8'hC5; wrBuf[2] = 8'hFB;
    doWrite(8'h00, 3);
    chk(ctrlQ == 8'hF0, "R6", ctrlQ, 8'hF0);
    doRead(8'h00, 3);

    // soft reset R7
    wrBuf[0] = 8'h04;
    doWrite(8'h02, 1);
    chk(vsel0Q == 8'h97 && ctrlQ == 8'h80, "R7", ctrlQ, 8'h80);
    doRead(8'h02, 1);

    // read-only writes R8, unmapped R11
    wrBuf[0] = 8'hFF; wrBuf[1] = 8'hFF; wrBuf[2] = 8'hFF;
    doWrite(8'h03, 3);
    doRead(8'h03, 3);
    wrBuf[0] = 8'h55; wrBuf[1] = 8'hAA;
    doWrite(8'h06, 2);
    doRead(8'h06, 2);

    // wrong address R2
    busStart();
    sendByte({7'h41, 1'b0}, ack); chk(ack == 1'b1, "R2", {7'b0, ack}, 8'h01);
    sendByte(8'h00, ack);         chk(ack == 1'b1, "R2", {7'b0, ack}, 8'h01);
    sendByte(8'h12, ack);         chk(ack == 1'b1, "R2", {7'b0, ack}, 8'h01);
    busStop();
    checkPorts("R2");

    // STOP inside a data byte R1
    busStart();
    sendByte({MY_ADDR, 1'b0}, ack);
    sendByte(8'h00, ack);
    for (int i = 0; i < 4; i++) sendBit(1'b0);
    busStop();
    checkPorts("R1");

    // START inside a data byte R1
    busStart();
    sendByte({MY_ADDR, 1'b0}, ack);
    sendByte(8'h01, ack);
    for (int i = 0; i < 3; i++) sendBit(1'b0);
    busStart();
    sendByte({MY_ADDR, 1'b0}, ack); chk(ack == 1'b0, "R1", {7'b0, ack}, 8'h00);
    sendByte(8'h00, ack);
    sendByte(8'h11, ack);
    busStop();
    modelWrite(0, 8'h11);
    checkPorts("R1");

    // random bursts R4 R10
    for (int it = 0; it < 30; it++) begin
      logic [7:0] p;
      int n;
      p = 8'($urandom_range(0, 7));
      n = $urandom_range(1, 3);
      pgood = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 1) == 0) begin
        for (int k = 0; k < 4; k++) wrBuf[k] = 8'($urandom);
        if (p + 8'(n) > 8'd2 && p <= 8'd2 && $urandom_range(0, 3) != 0) wrBuf[2 - p][2] = 1'b0;
        doWrite(p, n);
      end else begin
        doRead(p, n + 1);
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule